// File: doc/BRIEF.md
# Linear Image Sensor Drive Controller

This block sits on the host side of a clocked linear photodiode array. It drives the sensor clock and the combined start/hold pulse, and it raises an ADC sample strobe once per pixel, together with the index of that pixel. It keeps the sensor inside its timing rules. The clock phases have a minimum width. The start pulse has setup ahead of its capture edge and falls before the next edge. The clock stops low between frames. The next start comes only after N+1 clocks and a charge-transfer wait.

The integration time is set through a requested start-to-start spacing. A request outside the legal window is clamped to the nearest bound, and a sticky flag records the clamp. The first frame after the controller leaves idle only flushes stale charge. Its pixels are not strobed. All times are counted in system clock cycles. The default parameters suit a 250 MHz system clock: 20 us charge transfer, 100 ms ceiling, 120 ns settling and at most 8 MHz on the sensor clock.

Top module: `linescan_drive`

## Requirements
- R1: While reset is asserted and after its release with `run_en` low, `sensor_clk`, `sensor_si`, `adc_strobe`, `frame_done` and `range_err` are all 0.
- R2: The sensor clock has high and low phases of h system cycles each. h = max(`half_div`, HMIN), and HMIN = max(HALF_MIN, SETTLE_CYC/2+1). Each frame makes exactly N+1 rising edges, where N = `pix_count` (0 counts as 1). Between frames the clock stays low.
- R3: `sensor_si` rises while the sensor clock is low, h cycles before the capture edge (the first rising edge of a frame). It stays high through that clock's high phase and falls with its falling edge.
- R4: After each of the rising edges 1 to N, `adc_strobe` is high for one cycle, SETTLE_CYC cycles after that edge. `pix_idx` then reads 0 to N-1 in order. No strobe follows edge N+1.
- R5: `frame_done` is high for one cycle, in the first low cycle after edge N+1. It is never high together with `adc_strobe`.
- R6: The first frame after leaving idle runs in full but gives neither strobes nor `frame_done`.
- R7: The distance between consecutive capture edges is the request P = `int_req` + 18·2h, clamped to the range [N·2h + QT_CYC, MAXP_CYC].
- R8: `range_err` is set when a frame takes a request P that lies outside that range. It stays set until reset.
- R9: With `run_en` low at the end of a frame's last clock, or before the next start pulse would rise, the controller returns to idle. No further start pulse or clock is issued.
- R10: `half_div`, `pix_count` and `int_req` are sampled only when a frame starts. A change during a frame does not alter that frame's clock count or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Keep running frames while high |
| half_div | input | DIV_W | Requested sensor clock half period, in system cycles |
| pix_count | input | PIX_W | Number of pixels N in the chain |
| int_req | input | INT_W | Requested integration time, in system cycles |
| sensor_clk | output | 1 | Clock to the sensor |
| sensor_si | output | 1 | Start/hold pulse to the sensor |
| adc_strobe | output | 1 | One-cycle sample strobe for the current pixel |
| pix_idx | output | PIX_W | Index of the strobed pixel |
| frame_done | output | 1 | One-cycle pulse after the last sensor clock |
| range_err | output | 1 | Sticky flag: the requested integration was clamped |

## Verification
The bench builds the block with a 4-bit divider, an 8-bit pixel count, HALF_MIN of 2, SETTLE_CYC of 3, a 40-cycle charge transfer and a 2000-cycle ceiling. With these values a full frame takes a few hundred cycles. Both clamp bounds, the half-period floor and the flush frame after each restart can then all be reached in a short run. A behavioural model predicts every output on every cycle. Directed checks measure capture-to-capture spacing, edge counts, clock high width and strobe counts per frame.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_SCAN = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;
endpackage

// File: rtl/lsd_window.sv
// Clamps the raw settings into legal values and decides the frame period.
module lsd_window #(
  parameter int DIV_W      = 8,
  parameter int PIX_W      = 12,
  parameter int INT_W      = 32,
  parameter int TW         = 26,
  parameter int HALF_MIN   = 16,
  parameter int SETTLE_CYC = 30,
  parameter int QT_CYC     = 5000,
  parameter int MAXP_CYC   = 25000000
) (
  input  logic [DIV_W-1:0] half_div,
  input  logic [PIX_W-1:0] pix_count,
  input  logic [INT_W-1:0] int_req,
  output logic [DIV_W-1:0] half_eff,
  output logic [PIX_W-1:0] pix_eff,
  output logic [TW-1:0]    period_eff,
  output logic             out_of_range
);
  localparam int HMIN = (HALF_MIN > SETTLE_CYC/2 + 1) ? HALF_MIN : SETTLE_CYC/2 + 1;
  localparam int WW   = ((INT_W > TW) ? INT_W : TW) + 2;

  logic [WW-1:0] h_w, t_w, n_w, pmin_w, ptgt_w, clamp_w;

  always_comb begin
    half_eff = (half_div < DIV_W'(HMIN)) ? DIV_W'(HMIN) : half_div;
    pix_eff  = (pix_count == '0) ? PIX_W'(1) : pix_count;
    h_w      = WW'(half_eff);
    t_w      = h_w + h_w;
    n_w      = WW'(pix_eff);
    pmin_w   = n_w * t_w + WW'(QT_CYC);
    ptgt_w   = WW'(int_req) + WW'(18) * t_w;
    out_of_range = (ptgt_w < pmin_w) || (ptgt_w > WW'(MAXP_CYC));
    clamp_w  = (ptgt_w > WW'(MAXP_CYC)) ? WW'(MAXP_CYC) : ptgt_w;
    if (clamp_w < pmin_w) clamp_w = pmin_w;
    period_eff = TW'(clamp_w);
  end
endmodule

// File: rtl/lsd_sequencer.sv
// Frame state machine: lead-in, clocked scan, charge-transfer/integration gap.
module lsd_sequencer
  import lsd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PIX_W = 12,
  parameter int TW    = 26
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_en,
  input  logic [DIV_W-1:0] win_half,
  input  logic [PIX_W-1:0] win_pix,
  input  logic [TW-1:0]    win_period,
  input  logic             win_oor,
  output logic             sclk_o,
  output logic             si_o,
  output logic             done_o,
  output logic             err_o,
  output logic             scan_nx,
  output logic             flush_nx,
  output logic [DIV_W:0]   ph_nx,
  output logic [PIX_W-1:0] k_nx,
  output logic [PIX_W-1:0] n_nx,
  output logic             flush_o,
  output logic [PIX_W-1:0] n_o
);
  localparam logic [DIV_W:0]   PH_ONE = 1;
  localparam logic [PIX_W-1:0] K_ONE  = 1;
  localparam logic [TW-1:0]    E_ONE  = 1;

  phase_e           st_q, st_d;
  logic [DIV_W-1:0] h_q, h_d;
  logic [PIX_W-1:0] n_q, n_d, k_q, k_d;
  logic [TW-1:0]    p_q, p_d, e_q, e_d, h_t;
  logic [DIV_W:0]   ph_q, ph_d, hm1, tm1;
  logic             flush_q, flush_d, err_q, err_d;
  logic             sclk_q, sclk_d, si_q, si_d, done_q, done_d;
  logic             load, fin;

  always_comb begin
    st_d = st_q; h_d = h_q; n_d = n_q; p_d = p_q;
    k_d = k_q; ph_d = ph_q; e_d = e_q;
    flush_d = flush_q; err_d = err_q;
    load = 1'b0; fin = 1'b0;
    hm1 = {1'b0, h_q} - PH_ONE;
    tm1 = {h_q, 1'b0} - PH_ONE;
    h_t = TW'(h_q);
    unique case (st_q)
      PH_IDLE: begin
        if (run_en) begin
          st_d = PH_LEAD; ph_d = '0; flush_d = 1'b1; load = 1'b1;
        end
      end
      PH_LEAD: begin
        if (ph_q == hm1) begin
          st_d = PH_SCAN; ph_d = '0; k_d = '0; e_d = '0;
        end else begin
          ph_d = ph_q + PH_ONE;
        end
      end
      PH_SCAN: begin
        e_d = e_q + E_ONE;
        if ((k_q == n_q) && (ph_q == hm1)) begin
          fin  = 1'b1;
          st_d = run_en ? PH_GAP : PH_IDLE;
        end else if (ph_q == tm1) begin
          ph_d = '0; k_d = k_q + K_ONE;
        end else begin
          ph_d = ph_q + PH_ONE;
        end
      end
      PH_GAP: begin
        if (e_q == p_q - E_ONE) begin
          st_d = PH_SCAN; ph_d = '0; k_d = '0; e_d = '0;
          flush_d = 1'b0; load = 1'b1;
        end else if ((e_q + E_ONE == p_q - h_t) && !run_en) begin
          st_d = PH_IDLE;
        end else begin
          e_d = e_q + E_ONE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
    if (load) begin
      h_d = win_half; n_d = win_pix; p_d = win_period;
      err_d = err_q | win_oor;
    end
    sclk_d = (st_d == PH_SCAN) && ({1'b0, h_d} > ph_d);
    si_d   = (st_d == PH_LEAD)
           || ((st_d == PH_SCAN) && (k_d == '0) && ({1'b0, h_d} > ph_d))
           || ((st_d == PH_GAP) && (e_d >= p_d - TW'(h_d)));
    done_d = fin & ~flush_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PH_IDLE; h_q <= '0; n_q <= '0; p_q <= '0;
      k_q <= '0; ph_q <= '0; e_q <= '0;
      flush_q <= 1'b0; err_q <= 1'b0;
      sclk_q <= 1'b0; si_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; h_q <= h_d; n_q <= n_d; p_q <= p_d;
      k_q <= k_d; ph_q <= ph_d; e_q <= e_d;
      flush_q <= flush_d; err_q <= err_d;
      sclk_q <= sclk_d; si_q <= si_d; done_q <= done_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign si_o     = si_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign scan_nx  = (st_d == PH_SCAN);
  assign flush_nx = flush_d;
  assign ph_nx    = ph_d;
  assign k_nx     = k_d;
  assign n_nx     = n_d;
  assign flush_o  = flush_q;
  assign n_o      = n_q;

  // R3: the start pulse only rises while the sensor clock is low
  assert_si_rise_low_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(si_q) |-> !sclk_q);
  // R5: end-of-frame pulse lands in a low clock phase
  assert_done_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |-> !sclk_q);
  // R7: elapsed count in the gap never passes the frame period
  assert_gap_window_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == PH_GAP) |-> (e_q < p_q));
  // R8: the range flag is sticky
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/lsd_pixel_tap.sv
// Places the ADC strobe a fixed settling delay after each pixel clock edge.
module lsd_pixel_tap #(
  parameter int DIV_W      = 8,
  parameter int PIX_W      = 12,
  parameter int SETTLE_CYC = 30
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             scan_nx,
  input  logic             flush_nx,
  input  logic [DIV_W:0]   ph_nx,
  input  logic [PIX_W-1:0] k_nx,
  input  logic [PIX_W-1:0] n_nx,
  input  logic             flush_q,
  input  logic [PIX_W-1:0] n_q,
  output logic             strobe_o,
  output logic [PIX_W-1:0] idx_o
);
  localparam logic [DIV_W:0] SETTLE_PH = (DIV_W+1)'(SETTLE_CYC);

  logic             stb_d, stb_q;
  logic [PIX_W-1:0] idx_q;

  always_comb begin
    stb_d = scan_nx & ~flush_nx & (ph_nx == SETTLE_PH) & (k_nx < n_nx);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      idx_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (stb_d) idx_q <= k_nx;
    end
  end

  assign strobe_o = stb_q;
  assign idx_o    = idx_q;

  // R6: no strobe leaves the block during a flush frame
  assert_no_flush_strobe_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    stb_q |-> !flush_q);
  // R4: strobed index stays below the frame's pixel count
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    stb_q |-> (idx_q < n_q));
endmodule

// File: rtl/linescan_drive.sv
module linescan_drive #(
  parameter int DIV_W      = 8,
  parameter int PIX_W      = 12,
  parameter int INT_W      = 32,
  parameter int HALF_MIN   = 16,
  parameter int SETTLE_CYC = 30,
  parameter int QT_CYC     = 5000,
  parameter int MAXP_CYC   = 25000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] half_div,
  input  logic [PIX_W-1:0] pix_count,
  input  logic [INT_W-1:0] int_req,
  output logic             sensor_clk,
  output logic             sensor_si,
  output logic             adc_strobe,
  output logic [PIX_W-1:0] pix_idx,
  output logic             frame_done,
  output logic             range_err
);
  localparam int TW_A = $clog2(MAXP_CYC + 1);
  localparam int TW_B = PIX_W + DIV_W + 2;
  localparam int TW   = ((TW_A > TW_B) ? TW_A : TW_B) + 1;

  logic [1:0]       rs_q;
  logic             rst_i;
  logic [DIV_W-1:0] w_half;
  logic [PIX_W-1:0] w_pix, n_nx, k_nx, n_q;
  logic [TW-1:0]    w_period;
  logic             w_oor, scan_nx, flush_nx, flush_q;
  logic [DIV_W:0]   ph_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  lsd_window #(
    .DIV_W(DIV_W), .PIX_W(PIX_W), .INT_W(INT_W), .TW(TW),
    .HALF_MIN(HALF_MIN), .SETTLE_CYC(SETTLE_CYC),
    .QT_CYC(QT_CYC), .MAXP_CYC(MAXP_CYC)
  ) u_win (
    .half_div(half_div), .pix_count(pix_count), .int_req(int_req),
    .half_eff(w_half), .pix_eff(w_pix), .period_eff(w_period),
    .out_of_range(w_oor)
  );

  lsd_sequencer #(.DIV_W(DIV_W), .PIX_W(PIX_W), .TW(TW)) u_seq (
    .clk(clk), .rst_ni(rst_i), .run_en(run_en),
    .win_half(w_half), .win_pix(w_pix), .win_period(w_period), .win_oor(w_oor),
    .sclk_o(sensor_clk), .si_o(sensor_si), .done_o(frame_done), .err_o(range_err),
    .scan_nx(scan_nx), .flush_nx(flush_nx), .ph_nx(ph_nx), .k_nx(k_nx),
    .n_nx(n_nx), .flush_o(flush_q), .n_o(n_q)
  );

  lsd_pixel_tap #(.DIV_W(DIV_W), .PIX_W(PIX_W), .SETTLE_CYC(SETTLE_CYC)) u_tap (
    .clk(clk), .rst_ni(rst_i), .scan_nx(scan_nx), .flush_nx(flush_nx),
    .ph_nx(ph_nx), .k_nx(k_nx), .n_nx(n_nx), .flush_q(flush_q), .n_q(n_q),
    .strobe_o(adc_strobe), .idx_o(pix_idx)
  );

  // R5: strobe and frame end never coincide
  assert_strobe_apart_done_R5: assert property (@(posedge clk) disable iff (!rst_i)
    !(adc_strobe && frame_done));
endmodule

// File: tb/linescan_drive_tb.sv
`timescale 1ns/100ps
module linescan_drive_tb;
  localparam int DIV_W = 4, PIX_W = 8, INT_W = 16;
  localparam int HALF_MIN = 2, SETTLE = 3, QT = 40, MAXP = 2000;
  localparam int HMIN = (HALF_MIN > SETTLE/2 + 1) ? HALF_MIN : SETTLE/2 + 1;
  localparam int WD = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, run_en;
  logic [DIV_W-1:0] half_div;
  logic [PIX_W-1:0] pix_count;
  logic [INT_W-1:0] int_req;
  logic             sensor_clk, sensor_si, adc_strobe, frame_done, range_err;
  logic [PIX_W-1:0] pix_idx;

  linescan_drive #(.DIV_W(DIV_W), .PIX_W(PIX_W), .INT_W(INT_W), .HALF_MIN(HALF_MIN),
    .SETTLE_CYC(SETTLE), .QT_CYC(QT), .MAXP_CYC(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .half_div(half_div),
    .pix_count(pix_count), .int_req(int_req), .sensor_clk(sensor_clk),
    .sensor_si(sensor_si), .adc_strobe(adc_strobe), .pix_idx(pix_idx),
    .frame_done(frame_done), .range_err(range_err));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff_h(input int h);
    return (h < HMIN) ? HMIN : h;
  endfunction
  function automatic int eff_n(input int n);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic int req_p(input int h, input int n, input int r);
    return r + 18 * 2 * eff_h(h);
  endfunction
  function automatic int min_p(input int h, input int n);
    return eff_n(n) * 2 * eff_h(h) + QT;
  endfunction
  function automatic int period_exp(input int h, input int n, input int r);
    int p;
    p = req_p(h, n, r);
    if (p > MAXP) p = MAXP;
    if (p < min_p(h, n)) p = min_p(h, n);
    return p;
  endfunction

  // behavioural reference model
  int m_mode, m_cnt, m_t, m_H, m_N, m_T, m_P;
  bit m_flush, m_err, m_done;

  task automatic m_latch();
    m_H = eff_h(int'(half_div));
    m_N = eff_n(int'(pix_count));
    m_T = 2 * m_H;
    m_P = period_exp(int'(half_div), int'(pix_count), int'(int_req));
    if (req_p(int'(half_div), int'(pix_count), int'(int_req)) > MAXP ||
        req_p(int'(half_div), int'(pix_count), int'(int_req)) < min_p(int'(half_div), int'(pix_count)))
      m_err = 1'b1;
  endtask

  task automatic m_step();
    m_done = 1'b0;
    case (m_mode)
      0: if (run_en) begin m_latch(); m_mode = 1; m_cnt = 0; m_flush = 1'b1; end
      1: if (m_cnt == m_H - 1) begin m_mode = 2; m_t = 0; end else m_cnt++;
      default: begin
        if (m_t == m_N * m_T + m_H - 1) begin
          m_done = !m_flush;
          if (!run_en) m_mode = 0; else m_t++;
        end else if (m_t == m_P - 1) begin
          m_t = 0; m_flush = 1'b0; m_latch();
        end else if ((m_t + 1 == m_P - m_H) && !run_en) begin
          m_mode = 0;
        end else m_t++;
      end
    endcase
  endtask

  // measurements
  int cyc = 0, ncap = 0, last_cap = 0, last_period = 0;
  int rises = 0, last_rises = 0, stbs = 0, last_stbs = 0, dones = 0, last_dones = 0;
  int hi_run = 0, last_hi = 0;
  bit prev_sclk = 1'b0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst_n) begin
      m_mode = 0; m_err = 1'b0; m_done = 1'b0; m_flush = 1'b0;
      prev_sclk = 1'b0; hi_run = 0;
    end else begin
      bit e_sclk, e_si, e_stb;
      m_step();
      e_sclk = (m_mode == 2) && (m_t < m_N * m_T + m_H) && ((m_t % m_T) < m_H);
      e_si   = (m_mode == 1) || ((m_mode == 2) && (m_t < m_H || m_t >= m_P - m_H));
      e_stb  = (m_mode == 2) && !m_flush && ((m_t % m_T) == SETTLE) && ((m_t / m_T) < m_N);
      chk(sensor_clk == e_sclk, "R2", "sensor_clk", sensor_clk, e_sclk);
      chk(sensor_si == e_si, "R3", "sensor_si", sensor_si, e_si);
      chk(adc_strobe == e_stb, "R4", "adc_strobe", adc_strobe, e_stb);
      if (e_stb) chk(int'(pix_idx) == m_t / m_T, "R4", "pix_idx", pix_idx, m_t / m_T);
      chk(frame_done == m_done, "R5", "frame_done", frame_done, m_done);
      chk(range_err == m_err, "R8", "range_err", range_err, m_err);
      if (sensor_clk && !prev_sclk) begin
        if (sensor_si) begin
          last_period = cyc - last_cap; last_cap = cyc;
          last_rises = rises; last_stbs = stbs; last_dones = dones;
          rises = 1; stbs = 0; dones = 0; ncap++;
        end else rises++;
      end
      if (sensor_clk) hi_run++;
      else if (prev_sclk) begin last_hi = hi_run; hi_run = 0; end
      if (adc_strobe) stbs++;
      if (frame_done) dones++;
      prev_sclk = sensor_clk;
    end
  end

  task automatic wait_caps(input int n);
    int s;
    s = ncap;
    wait (ncap >= s + n);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++; fails++;
    $display("FAIL all watchdog expired: actual=%0d expected<%0d cycles", WD, WD);
    finish_run();
  end

  initial begin
    int c0;
    rst_n = 1'b0; run_en = 1'b0; half_div = 4'd3; pix_count = 8'd20; int_req = 16'd200;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!sensor_clk && !sensor_si && !adc_strobe && !frame_done && !range_err,
        "R1", "outputs in reset", {sensor_clk, sensor_si, adc_strobe, frame_done, range_err}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!sensor_clk && !sensor_si && !range_err, "R1", "outputs after release",
        {sensor_clk, sensor_si, range_err}, 0);

    run_en = 1'b1;
    wait_caps(2);
    chk(last_stbs == 0, "R6", "strobes in flush frame", last_stbs, 0);
    chk(last_dones == 0, "R6", "done in flush frame", last_dones, 0);
    wait_caps(1);
    chk(last_stbs == 20, "R4", "strobes per frame", last_stbs, 20);
    chk(last_dones == 1, "R5", "done per frame", last_dones, 1);
    chk(last_rises == 21, "R2", "rising edges per frame", last_rises, 21);
    chk(last_period == 308, "R7", "period in range", last_period, 308);
    chk(last_hi == 3, "R2", "clock high width", last_hi, 3);
    chk(range_err == 1'b0, "R8", "no clamp yet", range_err, 0);

    int_req = 16'd10;
    wait_caps(3);
    chk(last_period == period_exp(3, 20, 10), "R7", "low clamp", last_period, period_exp(3, 20, 10));
    chk(range_err == 1'b1, "R8", "flag after low clamp", range_err, 1);

    int_req = 16'd5000;
    wait_caps(3);
    chk(last_period == MAXP, "R7", "ceiling clamp", last_period, MAXP);
    chk(range_err == 1'b1, "R8", "flag sticky", range_err, 1);

    int_req = 16'd200; half_div = 4'd1;
    wait_caps(3);
    chk(last_hi == HMIN, "R2", "half period floor", last_hi, HMIN);
    chk(last_period == period_exp(1, 20, 200), "R7", "period fast clock", last_period, period_exp(1, 20, 200));

    wait_caps(1);
    repeat (10) @(negedge clk);
    pix_count = 8'd12;
    wait_caps(1);
    chk(last_rises == 21, "R10", "mid-frame change ignored", last_rises, 21);
    wait_caps(1);
    chk(last_rises == 13, "R10", "new count next frame", last_rises, 13);

    repeat (5) @(negedge clk);
    run_en = 1'b0;
    c0 = ncap;
    repeat (3000) @(negedge clk);
    chk(ncap == c0, "R9", "no start after stop", ncap, c0);
    chk(!sensor_clk && !sensor_si, "R9", "idle pins", {sensor_clk, sensor_si}, 0);
    chk(dones == 1, "R9", "last frame completed", dones, 1);

    run_en = 1'b1;
    wait_caps(2);
    chk(last_stbs == 0, "R6", "flush after restart", last_stbs, 0);
    wait_caps(1);
    chk(last_stbs == 12, "R4", "strobes after restart", last_stbs, 12);

    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sensor_clk && !sensor_si && !adc_strobe && !frame_done && !range_err,
        "R1", "outputs after mid-run reset", {sensor_clk, sensor_si, adc_strobe, frame_done, range_err}, 0);
    chk(range_err == 1'b0, "R8", "flag cleared by reset", range_err, 0);
    finish_run();
  end
endmodule